// File: doc/BRIEF.md
# Banked Interrupt Control Unit

This block gathers level-style interrupt requests for one CPU into a small number of identical control modules. Each module serves 32 request lines. It latches every request into a sticky pending word and masks that word with a per-line enable. It drives one summary interrupt toward the CPU whenever any enabled line is pending. Software acknowledges a line by writing a one to its pending bit. The bank also computes the position of the highest enabled pending line, because service picks the most significant bit and treats lower bits as less trustworthy.

Software reaches every register through a simple word-wide register bus with byte addresses. Reads are combinational, and a write takes effect at the next clock edge. Each module owns an address window of 0x28 bytes, and module m starts at m*0x28. Two further words per module, a resend word and a mask word, are kept only as storage for software. The reset input is asserted asynchronously and released in step with the clock.

Top module: `icu_bank`

## Requirements
- R1: Module m's window starts at byte address m*0x28. Inside a window the byte offsets are: 0x00 pending, 0x04 pending index, 0x08 enable, 0x10 enabled-pending, 0x18 resend, 0x20 mask.
- R2: A pending bit is set at the clock edge after any cycle in which its request line is high. It stays set after the request drops.
- R3: Writing the pending word clears each bit written as 1 and leaves each bit written as 0 unchanged. If a request is high in the same cycle as a clearing write to its bit, the bit stays set.
- R4: The enable word reads back what was last written. The enabled-pending word reads as pending AND enable, and writes to it are ignored.
- R5: irq_out[m] is high exactly when module m's enabled-pending word is non-zero.
- R6: The pending-index word holds the position of the most significant set bit of the enabled-pending word in bits 4:0, with bit 31 as a valid flag. When the enabled-pending word is zero, the whole index word reads 0.
- R7: The resend and mask words read back what was last written. They have no effect on pending state, enabled-pending state or irq_out.
- R8: While reset is active, and after it, until the first write, pending, enable and resend read 0, mask reads 0xFFFFFFFF, and every irq_out bit is low.
- R9: Byte offsets 0x0C, 0x14, 0x1C, 0x24 and any offset not a multiple of 4 read 0 and ignore writes. Addresses at or beyond NUM_MOD*0x28 behave the same way.
- R10: A write happens only when bus_en and bus_we are both high. bus_rdata is 0 whenever bus_en is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with the clock |
| irq_req | input | NUM_MOD*32 | Request lines; module m uses bits m*32+31 down to m*32 |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_out | output | NUM_MOD | Summary interrupt, one per module |

## Verification
The assertions assume two things about the inputs. First, irq_req is never unknown. Second, the only thing that clears a pending bit is a bus write to that module's pending offset in the previous cycle. The stimulus meets both: it drives every request line to a known value every cycle, and it changes bus signals only away from the active edge. Random traffic covers the whole window set, unaligned bytes and addresses past the last window. It keeps requests sparse, so that acknowledges and index changes are actually seen and the pending words do not simply saturate.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int LINES  = 32;
  localparam int DW     = 32;
  localparam int IDX_W  = $clog2(LINES);
  localparam int STRIDE = 40;

  localparam logic [31:0] OFF_PEND  = 32'h00;
  localparam logic [31:0] OFF_INDEX = 32'h04;
  localparam logic [31:0] OFF_EN    = 32'h08;
  localparam logic [31:0] OFF_EPEND = 32'h10;
  localparam logic [31:0] OFF_RSND  = 32'h18;
  localparam logic [31:0] OFF_MASK  = 32'h20;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_PEND, SEL_INDEX, SEL_EN, SEL_EPEND, SEL_RSND, SEL_MASK
  } reg_sel_e;

  function automatic reg_sel_e decode_off(input logic [31:0] off);
    case (off)
      OFF_PEND:  return SEL_PEND;
      OFF_INDEX: return SEL_INDEX;
      OFF_EN:    return SEL_EN;
      OFF_EPEND: return SEL_EPEND;
      OFF_RSND:  return SEL_RSND;
      OFF_MASK:  return SEL_MASK;
      default:   return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/icu_rst_sync.sv
module icu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/icu_prio.sv
module icu_prio #(
  parameter int W = 32,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          valid
);
  always_comb begin
    idx   = '0;
    valid = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) begin
        idx   = IW'(i);
        valid = 1'b1;
      end
    end
  end
endmodule

// File: rtl/icu_regbank.sv
module icu_regbank
  import icu_pkg::*;
#(
  parameter int W = LINES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] req,
  input  reg_sel_e     sel,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] pend_q,
  output logic [W-1:0] en_q,
  output logic [W-1:0] rsnd_q,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] epend,
  output logic         irq
);
  logic [W-1:0] clr;
  logic [W-1:0] pend_d;
  logic         en_ld;
  logic         rsnd_ld;
  logic         mask_ld;

  // next state: a request sets its bit, and a set beats a clear in the same cycle
  always_comb begin
    clr     = (wr && sel == SEL_PEND) ? wdata : '0;
    pend_d  = (pend_q & ~clr) | req;
    en_ld   = wr && (sel == SEL_EN);
    rsnd_ld = wr && (sel == SEL_RSND);
    mask_ld = wr && (sel == SEL_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
      rsnd_q <= '0;
      mask_q <= '1;
    end else begin
      pend_q <= pend_d;
      if (en_ld)   en_q   <= wdata;
      if (rsnd_ld) rsnd_q <= wdata;
      if (mask_ld) mask_q <= wdata;
    end
  end

  assign epend = pend_q & en_q;
  assign irq   = |epend;
endmodule

// File: rtl/icu_bank.sv
module icu_bank
  import icu_pkg::*;
#(
  parameter int NUM_MOD = 5,
  parameter int ADDR_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_MOD*LINES-1:0] irq_req,
  input  logic                     bus_en,
  input  logic                     bus_we,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DW-1:0]            bus_wdata,
  output logic [DW-1:0]            bus_rdata,
  output logic [NUM_MOD-1:0]       irq_out
);
  localparam int SPAN = NUM_MOD * STRIDE;

  logic                     rst_sync_n;
  logic [31:0]              addr_ext;
  logic [NUM_MOD*LINES-1:0] pend_flat;
  logic [NUM_MOD*LINES-1:0] en_flat;
  logic [NUM_MOD-1:0]       idx_valid;
  logic [DW-1:0]            rd_m [NUM_MOD];

  icu_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign addr_ext = 32'(bus_addr);

  for (genvar m = 0; m < NUM_MOD; m++) begin : g_mod
    localparam logic [31:0] BASE = 32'(m * STRIDE);
    logic             hit;
    logic [31:0]      off;
    reg_sel_e         sel;
    logic [LINES-1:0] pend_q, en_q, rsnd_q, mask_q, epend;
    logic [IDX_W-1:0] idx;

    always_comb begin
      hit = bus_en && (addr_ext >= BASE) && (addr_ext < BASE + 32'(STRIDE));
      off = addr_ext - BASE;
      sel = hit ? decode_off(off) : SEL_NONE;
    end

    icu_regbank #(.W(LINES)) u_bank (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .req    (irq_req[m*LINES +: LINES]),
      .sel    (sel),
      .wr     (bus_we),
      .wdata  (bus_wdata),
      .pend_q (pend_q),
      .en_q   (en_q),
      .rsnd_q (rsnd_q),
      .mask_q (mask_q),
      .epend  (epend),
      .irq    (irq_out[m])
    );

    icu_prio #(.W(LINES)) u_prio (
      .vec   (epend),
      .idx   (idx),
      .valid (idx_valid[m])
    );

    always_comb begin
      case (sel)
        SEL_PEND:  rd_m[m] = pend_q;
        SEL_INDEX: rd_m[m] = {idx_valid[m], {(DW-1-IDX_W){1'b0}}, idx};
        SEL_EN:    rd_m[m] = en_q;
        SEL_EPEND: rd_m[m] = epend;
        SEL_RSND:  rd_m[m] = rsnd_q;
        SEL_MASK:  rd_m[m] = mask_q;
        default:   rd_m[m] = '0;
      endcase
    end

    assign pend_flat[m*LINES +: LINES] = pend_q;
    assign en_flat[m*LINES +: LINES]   = en_q;
  end

  // at most one window is hit, so OR-merging the module read words is enough
  always_comb begin
    bus_rdata = '0;
    for (int m = 0; m < NUM_MOD; m++) bus_rdata = bus_rdata | rd_m[m];
  end
endmodule

// File: rtl/icu_bank_chk.sv
module icu_bank_chk #(
  parameter int NUM_MOD = 5,
  parameter int ADDR_W  = 8
) (
  input logic                  clk,
  input logic                  rst_ok,
  input logic [NUM_MOD*32-1:0] irq_req,
  input logic                  bus_en,
  input logic                  bus_we,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [31:0]           bus_rdata,
  input logic [NUM_MOD-1:0]    irq_out,
  input logic [NUM_MOD*32-1:0] pend_flat,
  input logic [NUM_MOD*32-1:0] en_flat,
  input logic [NUM_MOD-1:0]    idx_valid
);
  localparam int SPAN = NUM_MOD * 40;
  logic [31:0] addr_ext;
  assign addr_ext = 32'(bus_addr);

  assert_req_sets_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    (|irq_req) |=> (($past(irq_req) & ~pend_flat) == '0));

  assert_outside_zero_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    (bus_en && addr_ext >= 32'(SPAN)) |-> (bus_rdata == '0));

  assert_idle_bus_zero_R10: assert property (@(posedge clk) disable iff (!rst_ok)
    !bus_en |-> (bus_rdata == '0));

  always @(posedge clk) begin
    if (!rst_ok) begin
      assert_reset_quiet_R8: assert (irq_out == '0 && en_flat == '0);
    end
  end

  for (genvar m = 0; m < NUM_MOD; m++) begin : g_chk
    assert_clear_by_write_R3: assert property (@(posedge clk) disable iff (!rst_ok)
      (|($past(pend_flat[m*32 +: 32]) & ~pend_flat[m*32 +: 32]))
        |-> $past(bus_en && bus_we && addr_ext == 32'(m*40)));

    assert_disabled_silent_R5: assert property (@(posedge clk) disable iff (!rst_ok)
      (en_flat[m*32 +: 32] == '0) |-> !irq_out[m]);

    assert_index_valid_R6: assert property (@(posedge clk) disable iff (!rst_ok)
      idx_valid[m] == irq_out[m]);
  end
endmodule

bind icu_bank icu_bank_chk #(.NUM_MOD(NUM_MOD), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_ok    (rst_sync_n),
  .irq_req   (irq_req),
  .bus_en    (bus_en),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .irq_out   (irq_out),
  .pend_flat (pend_flat),
  .en_flat   (en_flat),
  .idx_valid (idx_valid)
);

// File: tb/sim_icu_bank.sv
`timescale 1ns/1ps
module sim_icu_bank;
  localparam int NM = 5;
  localparam int AW = 8;
  localparam int ST = 40;
  localparam int SPAN = NM * ST;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NM*32-1:0] irq_req;
  logic            bus_en, bus_we;
  logic [AW-1:0]   bus_addr;
  logic [31:0]     bus_wdata;
  logic [31:0]     bus_rdata;
  logic [NM-1:0]   irq_out;

  always #2 clk = ~clk;

  icu_bank #(.NUM_MOD(NM), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  logic [31:0] m_pd [NM];
  logic [31:0] m_en [NM];
  logic [31:0] m_rs [NM];
  logic [31:0] m_mk [NM];
  int checks = 0;
  int errors = 0;

  function automatic logic [31:0] index_word(input logic [31:0] v);
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++) if (v[i]) r = 32'h8000_0000 | 32'(i);
    return r;
  endfunction

  function automatic logic [31:0] exp_read(input int a);
    int m, o;
    if (a >= SPAN) return '0;
    m = a / ST;
    o = a % ST;
    case (o)
      0:  return m_pd[m];
      4:  return index_word(m_pd[m] & m_en[m]);
      8:  return m_en[m];
      16: return m_pd[m] & m_en[m];
      24: return m_rs[m];
      32: return m_mk[m];
      default: return '0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // one bus cycle: drive away from the edge, check, advance the model across the edge
  task automatic cyc(input logic [NM*32-1:0] rq, input logic en, input logic we,
                     input int a, input logic [31:0] wd, input string tag);
    logic [31:0] exp_irq;
    logic [31:0] npd [NM];
    logic [31:0] nen [NM];
    logic [31:0] nrs [NM];
    logic [31:0] nmk [NM];
    logic [31:0] clr;
    @(negedge clk);
    irq_req = rq; bus_en = en; bus_we = we; bus_addr = AW'(a); bus_wdata = wd;
    #1;
    if (!we) chk(tag, bus_rdata, en ? exp_read(a) : 32'h0);
    exp_irq = '0;
    for (int m = 0; m < NM; m++) exp_irq[m] = |(m_pd[m] & m_en[m]);
    chk("R5 irq_out", 32'(irq_out), exp_irq);
    for (int m = 0; m < NM; m++) begin
      clr = '0;
      nen[m] = m_en[m]; nrs[m] = m_rs[m]; nmk[m] = m_mk[m];
      if (rst_n && en && we && a < SPAN && a / ST == m) begin
        case (a % ST)
          0:  clr = wd;
          8:  nen[m] = wd;
          24: nrs[m] = wd;
          32: nmk[m] = wd;
          default: ;
        endcase
      end
      npd[m] = (m_pd[m] & ~clr) | rq[m*32 +: 32];
    end
    @(posedge clk);
    for (int m = 0; m < NM; m++) begin
      m_pd[m] = npd[m]; m_en[m] = nen[m]; m_rs[m] = nrs[m]; m_mk[m] = nmk[m];
    end
  endtask

  task automatic rd(input int a, input string tag);
    cyc('0, 1'b1, 1'b0, a, 32'h0, tag);
  endtask

  task automatic wr(input int a, input logic [31:0] d, input string tag);
    cyc('0, 1'b1, 1'b1, a, d, tag);
  endtask

  function automatic logic [NM*32-1:0] one_req(input int m, input int b);
    logic [NM*32-1:0] r = '0;
    r[m*32 + b] = 1'b1;
    return r;
  endfunction

  initial begin
    #(4 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240411));
    for (int m = 0; m < NM; m++) begin
      m_pd[m] = '0; m_en[m] = '0; m_rs[m] = '0; m_mk[m] = '1;
    end
    rst_n = 1'b0; irq_req = '0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    rd(32, "R8 mask during reset");
    rd(8,  "R8 enable during reset");
    @(negedge clk);
    rst_n = 1'b1;
    rd(0,  "R8 pending after reset");
    rd(0 + 3*ST + 32, "R8 mask m3 after reset");
    rd(24, "R8 resend after reset");

    // R4 enable readback, R2 sticky set
    wr(8, 32'hFFFF_FFFF, "R4 write enable");
    rd(8, "R4 enable readback");
    cyc(one_req(0, 5), 1'b0, 1'b0, 0, 32'h0, "R10 idle rdata");
    rd(0, "R2 sticky pending bit 5");
    rd(16, "R4 enabled-pending");
    // R3 acknowledge
    wr(0, 32'h0, "R3 write zeros");
    rd(0, "R3 zeros leave bit set");
    wr(0, 32'h20, "R3 clear bit 5");
    rd(0, "R3 bit 5 cleared");
    cyc(one_req(0, 7), 1'b1, 1'b1, 0, 32'h80, "R3 set wins");
    rd(0, "R3 set beats clear");
    wr(0, 32'h80, "R3 clear bit 7");

    // R6 priority index on module 2 (R1 window base 0x50)
    wr(2*ST + 8, 32'h8000_0001, "R1 enable m2");
    cyc(one_req(2, 0) | one_req(2, 31) | one_req(2, 9), 1'b0, 1'b0, 0, 0, "R10 idle");
    rd(2*ST + 4, "R6 index highest 31");
    wr(2*ST, 32'h8000_0000, "R6 ack 31");
    rd(2*ST + 4, "R6 index falls to 0");
    wr(2*ST, 32'h1, "R6 ack 0");
    rd(2*ST + 4, "R6 index empty");
    rd(2*ST, "R6 masked bit 9 still pending");

    // R7 storage only
    wr(ST + 24, 32'hA5A5_0F0F, "R7 resend write");
    wr(ST + 32, 32'h0000_0000, "R7 mask write");
    rd(ST + 24, "R7 resend readback");
    rd(ST + 32, "R7 mask readback");
    rd(ST + 16, "R7 no effect on enabled-pending");

    // R9 holes and out of range
    wr(12, 32'hFFFF_FFFF, "R9 hole write");
    rd(12, "R9 hole reads zero");
    wr(9, 32'h0, "R9 unaligned write");
    rd(8, "R9 unaligned ignored");
    wr(SPAN, 32'hFFFF_FFFF, "R9 beyond write");
    rd(SPAN, "R9 beyond reads zero");
    rd(4*ST + 36, "R9 last hole");

    // R10 strobe required
    cyc('0, 1'b0, 1'b1, 3*ST + 8, 32'hFFFF_FFFF, "R10 write without strobe");
    rd(3*ST + 8, "R10 enable untouched");

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [NM*32-1:0] rq;
      int op, a;
      for (int m = 0; m < NM; m++) rq[m*32 +: 32] = $urandom & $urandom & $urandom & $urandom;
      op = $urandom % 8;
      a  = ($urandom % (SPAN + 16));
      if (($urandom % 4) != 0) a = a & ~3;
      case (op)
        0, 1, 2: cyc(rq, 1'b1, 1'b0, a, 0, "R1 random read");
        3: cyc(rq, 1'b1, 1'b1, (a / ST) * ST, $urandom, "R3 random ack");
        4: cyc(rq, 1'b1, 1'b1, (a / ST) * ST + 8, $urandom, "R4 random enable");
        5: cyc(rq, 1'b1, 1'b1, (a / ST) * ST + ((($urandom % 2) != 0) ? 24 : 32), $urandom, "R7 random store");
        6: cyc(rq, 1'b1, 1'b1, a, $urandom, "R9 random write");
        default: cyc(rq, 1'b0, 1'b0, a, 0, "R10 random idle");
      endcase
    end
    for (int m = 0; m < NM; m++) rd(m*ST + 4, "R6 final index");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule